// File: doc/BRIEF.md
# Windowed Register File

This block is a 32-bit general-purpose register file whose physical storage is larger than what an instruction can name. A 4-bit logical register number reaches one of 16 registers through a movable window. The window sits over a bank of 32 or 64 physical registers, set by a parameter. Because the window moves, register fields in instructions stay small. A called routine can also get fresh registers by moving the window forward, so nothing has to be saved or restored.

The window base is held in groups of four registers. A rotate command moves it forward or backward by 4, 8 or 12 registers, and the move takes effect at the next clock edge. Every logical number is added to the base and wraps modulo the bank size. Each group carries a live bit that marks it as owned by a suspended frame. When a forward move brings such a group into the window, the block raises a one-cycle wrap flag. Handling that condition, including spilling registers to memory, belongs to logic outside this block.

The register and rotate pins are plain control pins with no handshake. Every command is accepted in the cycle it is presented, and there is no back-pressure.

Top module: `winreg_file`

## Requirements
- R1: After reset the window base reads 0, the wrap flag is 0, and no group is live, so the first forward moves raise no wrap flag.
- R2: A read port returns physical register (4*base + logical index) mod PHYS_REGS. A write with wr_en high stores wr_data into the physical register given by the same mapping at the clock edge.
- R3: With rot_valid=1, rot_dir=0 (forward) and rot_amt=k (k=1,2,3 means 4, 8, 12 registers), the base becomes (base + k) mod (PHYS_REGS/4) at the next edge.
- R4: With rot_valid=1, rot_dir=1 (backward) and rot_amt=k, the base becomes (base - k) mod (PHYS_REGS/4) at the next edge, wrapping below zero.
- R5: The base does not change when rot_valid=0, whatever rot_amt is, or when rot_amt=0.
- R6: A window that runs past the top of the bank continues at physical register 0. For example, at base 5 of a 32-entry bank, logical 12 is physical 0.
- R7: When a write is presented in a cycle, a read port with the same logical index returns wr_data in that same cycle.
- R8: A forward move of k marks the k groups leaving the bottom of the window as live. If any of the k groups entering at the top is already live, wrap_flag is 1 in the cycle after the move only. Otherwise wrap_flag stays 0.
- R9: A backward move of k clears the live bits of the k groups it brings back into the bottom of the window. After that, a later forward move onto those groups raises no wrap flag.
- R10: A write presented in the same cycle as a rotate uses the base from before the rotate.
- R11: The two read ports are independent. Each returns its own register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rd0_idx | input | 4 | Logical register for read port 0 |
| rd0_data | output | 32 | Read port 0 data, combinational |
| rd1_idx | input | 4 | Logical register for read port 1 |
| rd1_data | output | 32 | Read port 1 data, combinational |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Logical register to write |
| wr_data | input | 32 | Write data |
| rot_valid | input | 1 | Rotate command present |
| rot_dir | input | 1 | 0 forward, 1 backward |
| rot_amt | input | 2 | Rotate amount in groups of four registers |
| win_base | output | log2(PHYS_REGS/4) | Current window base in groups |
| wrap_flag | output | 1 | One-cycle flag: a forward move landed on a live group |

## Verification
The assertions check, on every cycle, the base step for forward moves, backward moves and idle commands. They also check that the wrap flag never follows anything other than a forward move, and that a same-cycle write reaches both read ports. Only the bench's scenarios can show that the read mapping wraps across the bank end, and that the live bits rise and clear in the right groups over a sequence of moves. The clearing on backward moves is one such case: a forward move that follows only stays quiet if it was done. The bench scenarios also cover a write issued together with a rotate, which must land at the pre-rotate location.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  localparam int GRP_SIZE   = 4;  // registers per window step
  localparam int WIN_GROUPS = 4;  // 16-register window
  localparam int LIDX_W     = 4;
  localparam int AMT_W      = 2;
  typedef enum logic { ROT_FWD = 1'b0, ROT_BACK = 1'b1 } rot_dir_e;
endpackage

// File: rtl/wrf_xlate.sv
module wrf_xlate #(
  parameter int BASE_W = 3,
  localparam int PIDX_W = BASE_W + 2
) (
  input  logic [BASE_W-1:0]          base,
  input  logic [wrf_pkg::LIDX_W-1:0] lidx,
  output logic [PIDX_W-1:0]          pidx
);
  // truncation to PIDX_W gives the modulo-bank wrap
  assign pidx = {base, 2'b00} + PIDX_W'(lidx);
endmodule

// File: rtl/wrf_window_ctl.sv
module wrf_window_ctl #(
  parameter int NGROUPS = 8,
  localparam int BASE_W = $clog2(NGROUPS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rot_valid,
  input  logic                      rot_dir,
  input  logic [wrf_pkg::AMT_W-1:0] rot_amt,
  output logic [BASE_W-1:0]         base,
  output logic                      wrap
);
  import wrf_pkg::*;

  logic [NGROUPS-1:0] live_q;
  logic [NGROUPS-1:0] leave_m, enter_m, back_m;
  logic [BASE_W-1:0]  amt_g, base_nxt;
  logic               act, fwd, collide;

  assign amt_g = BASE_W'(rot_amt);
  assign act   = rot_valid && (rot_amt != '0);
  assign fwd   = (rot_dir_e'(rot_dir) == ROT_FWD);
  assign base_nxt = fwd ? base + amt_g : base - amt_g;

  always_comb begin
    leave_m = '0;
    enter_m = '0;
    back_m  = '0;
    for (int j = 0; j < WIN_GROUPS - 1; j++) begin
      if (j < int'(rot_amt)) begin
        leave_m[base + BASE_W'(j)]                      = 1'b1;
        enter_m[base + BASE_W'(j) + BASE_W'(WIN_GROUPS)] = 1'b1;
        back_m[base - BASE_W'(j) - BASE_W'(1)]          = 1'b1;
      end
    end
  end

  assign collide = |(enter_m & live_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base   <= '0;
      live_q <= '0;
      wrap   <= 1'b0;
    end else begin
      wrap <= act && fwd && collide;
      if (act) begin
        base   <= base_nxt;
        live_q <= fwd ? (live_q | leave_m) : (live_q & ~back_m);
      end
    end
  end
endmodule

// File: rtl/wrf_bank.sv
module wrf_bank #(
  parameter int DATA_W = 32,
  parameter int NREGS  = 32,
  parameter int NRD    = 2,
  localparam int PIDX_W = $clog2(NREGS)
) (
  input  logic                        clk,
  input  logic                        we,
  input  logic [PIDX_W-1:0]           waddr,
  input  logic [DATA_W-1:0]           wdata,
  input  logic [NRD-1:0][PIDX_W-1:0]  raddr,
  output logic [NRD-1:0][DATA_W-1:0]  rdata
);
  logic [DATA_W-1:0] mem [NREGS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rdata[r] = (we && (waddr == raddr[r])) ? wdata : mem[raddr[r]];
  end
endmodule

// File: rtl/winreg_file.sv
module winreg_file #(
  parameter int DATA_W    = 32,
  parameter int PHYS_REGS = 32,
  localparam int NGROUPS  = PHYS_REGS / wrf_pkg::GRP_SIZE,
  localparam int BASE_W   = $clog2(NGROUPS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [3:0]                rd0_idx,
  output logic [DATA_W-1:0]         rd0_data,
  input  logic [3:0]                rd1_idx,
  output logic [DATA_W-1:0]         rd1_data,
  input  logic                      wr_en,
  input  logic [3:0]                wr_idx,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic                      rot_valid,
  input  logic                      rot_dir,
  input  logic [1:0]                rot_amt,
  output logic [BASE_W-1:0]         win_base,
  output logic                      wrap_flag
);
  localparam int PIDX_W = $clog2(PHYS_REGS);
  localparam int NPORT  = 3;  // two reads, one write

  logic [NPORT-1:0][3:0]        lidx;
  logic [NPORT-1:0][PIDX_W-1:0] pidx;
  logic [1:0][DATA_W-1:0]       rdata;

  assign lidx = {wr_idx, rd1_idx, rd0_idx};

  wrf_window_ctl #(.NGROUPS(NGROUPS)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .rot_valid(rot_valid), .rot_dir(rot_dir), .rot_amt(rot_amt),
    .base(win_base), .wrap(wrap_flag)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_xl
    wrf_xlate #(.BASE_W(BASE_W)) u_xl (
      .base(win_base), .lidx(lidx[p]), .pidx(pidx[p])
    );
  end

  wrf_bank #(.DATA_W(DATA_W), .NREGS(PHYS_REGS), .NRD(2)) u_bank (
    .clk(clk), .we(wr_en), .waddr(pidx[2]), .wdata(wr_data),
    .raddr(pidx[1:0]), .rdata(rdata)
  );

  assign rd0_data = rdata[0];
  assign rd1_data = rdata[1];
endmodule

// File: rtl/winreg_file_chk.sv
module winreg_file_chk #(
  parameter int DATA_W = 32,
  parameter int BASE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        rd0_idx,
  input logic [DATA_W-1:0] rd0_data,
  input logic [3:0]        rd1_idx,
  input logic [DATA_W-1:0] rd1_data,
  input logic              wr_en,
  input logic [3:0]        wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic              rot_valid,
  input logic              rot_dir,
  input logic [1:0]        rot_amt,
  input logic [BASE_W-1:0] win_base,
  input logic              wrap_flag
);
  p_fwd_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rot_valid && !rot_dir && rot_amt != 2'd0) |=>
      win_base == BASE_W'($past(win_base) + BASE_W'($past(rot_amt))));

  p_back_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rot_valid && rot_dir && rot_amt != 2'd0) |=>
      win_base == BASE_W'($past(win_base) - BASE_W'($past(rot_amt))));

  p_hold_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rot_valid || rot_amt == 2'd0) |=> $stable(win_base));

  p_wrap_after_fwd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rot_valid && !rot_dir && rot_amt != 2'd0) |=> !wrap_flag);

  p_bypass0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd0_idx == wr_idx) |-> rd0_data == wr_data);

  p_bypass1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd1_idx == wr_idx) |-> rd1_data == wr_data);
endmodule

bind winreg_file winreg_file_chk #(.DATA_W(DATA_W), .BASE_W(BASE_W)) u_chk (.*);

// File: tb/sim_winreg_file.sv
module sim_winreg_file;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rd0_idx = '0, rd1_idx = '0, wr_idx = '0;
  logic [31:0] rd0_data, rd1_data, wr_data = '0;
  logic        wr_en = 1'b0, rot_valid = 1'b0, rot_dir = 1'b0;
  logic [1:0]  rot_amt = '0;
  logic [2:0]  win_base;
  logic        wrap_flag;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  winreg_file u0 (.*);

  function automatic logic [31:0] val(int p);
    return 32'hC0DE_0000 + 32'(p);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] idx, input logic [31:0] d);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic rotate(input string req, input logic dir, input logic [1:0] amt,
                        input logic [2:0] exp_base, input logic exp_wrap);
    rot_valid = 1'b1; rot_dir = dir; rot_amt = amt;
    @(posedge clk); #2;
    rot_valid = 1'b0;
    chk(req, "base", 32'(win_base), 32'(exp_base));
    chk(req, "wrap", 32'(wrap_flag), 32'(exp_wrap));
  endtask

  task automatic read2(input string req, input logic [3:0] a, input logic [31:0] ea,
                       input logic [3:0] b, input logic [31:0] eb);
    rd0_idx = a; rd1_idx = b; #1;
    chk(req, "rd0", rd0_data, ea);
    chk(req, "rd1", rd1_data, eb);
  endtask

  task automatic t_reset;  // R1
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    chk("R1", "base after reset", 32'(win_base), 32'd0);
    chk("R1", "wrap after reset", 32'(wrap_flag), 32'd0);
  endtask

  task automatic t_read_write;  // R2, R11
    for (int i = 0; i < 16; i++) do_write(4'(i), val(i));
    for (int i = 0; i < 16; i++) read2("R2_R11", 4'(i), val(i), 4'(15 - i), val(15 - i));
  endtask

  task automatic t_forward;  // R3, R1 (no live groups yet)
    rotate("R3", 1'b0, 2'd2, 3'd2, 1'b0);
    read2("R2", 4'd0, val(8), 4'd7, val(15));
    for (int i = 8; i < 16; i++) do_write(4'(i), val(8 + i));
  endtask

  task automatic t_backward;  // R4
    rotate("R4", 1'b1, 2'd2, 3'd0, 1'b0);
    read2("R4", 4'd3, val(3), 4'd12, val(12));
  endtask

  task automatic t_noop;  // R5
    rotate("R5", 1'b0, 2'd0, 3'd0, 1'b0);
    rot_amt = 2'd3; rot_dir = 1'b0;
    @(posedge clk); #2;
    chk("R5", "base idle", 32'(win_base), 32'd0);
  endtask

  task automatic t_wrap_flag;  // R8
    rotate("R8", 1'b0, 2'd3, 3'd3, 1'b0);
    for (int i = 5; i < 16; i++) do_write(4'(i), val(12 + i));
    rotate("R8", 1'b0, 2'd1, 3'd4, 1'b0);
    for (int i = 12; i < 16; i++) do_write(4'(i), val(16 + i));
    rotate("R8", 1'b0, 2'd1, 3'd5, 1'b1);  // group 0 is live
    @(posedge clk); #2;
    chk("R8", "wrap pulse drops", 32'(wrap_flag), 32'd0);
  endtask

  task automatic t_bank_wrap;  // R6, at base 5
    read2("R6", 4'd11, val(31), 4'd12, val(0));
    read2("R6", 4'd15, val(3), 4'd0, val(20));
    do_write(4'd13, 32'h1111_0001);
    read2("R6", 4'd13, 32'h1111_0001, 4'd14, val(2));
  endtask

  task automatic t_back_clear;  // R9, R4 below zero
    rotate("R9", 1'b1, 2'd1, 3'd4, 1'b0);
    rotate("R9", 1'b1, 2'd3, 3'd1, 1'b0);
    rotate("R9", 1'b1, 2'd1, 3'd0, 1'b0);
    rotate("R4", 1'b1, 2'd3, 3'd5, 1'b0);
    rotate("R9", 1'b0, 2'd3, 3'd0, 1'b0);  // groups 1..3 were cleared
  endtask

  task automatic t_bypass;  // R7
    wr_en = 1'b1; wr_idx = 4'd6; wr_data = 32'hFEED_0006;
    rd0_idx = 4'd6; rd1_idx = 4'd7; #1;
    chk("R7", "same-cycle rd0", rd0_data, 32'hFEED_0006);
    chk("R7", "other rd1", rd1_data, val(7));
    @(posedge clk); #2;
    wr_en = 1'b0; #1;
    chk("R7", "after commit", rd0_data, 32'hFEED_0006);
  endtask

  task automatic t_write_rotate;  // R10
    wr_en = 1'b1; wr_idx = 4'd0; wr_data = 32'hABCD_0000;
    rot_valid = 1'b1; rot_dir = 1'b0; rot_amt = 2'd1;
    @(posedge clk); #2;
    wr_en = 1'b0; rot_valid = 1'b0;
    chk("R10", "base", 32'(win_base), 32'd1);
    read2("R10", 4'd0, val(4), 4'd3, val(7));
    rotate("R10", 1'b1, 2'd1, 3'd0, 1'b0);
    read2("R10", 4'd0, 32'hABCD_0000, 4'd1, 32'h1111_0001);
  endtask

  initial begin
    t_reset();
    t_read_write();
    t_forward();
    t_backward();
    t_noop();
    t_wrap_flag();
    t_bank_wrap();
    t_back_clear();
    t_bypass();
    t_write_rotate();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule